// File: doc/BRIEF.md
# UART Character FIFO Controller with Trigger Interrupts

This block holds the receive and transmit character queues of a 16550-style serial port, together with the 8-bit control field that configures them. A receive shifter hands in characters with a single-cycle push strobe, and a transmit shifter takes characters out with a single-cycle pop strobe. The host side pops received characters and pushes characters to send, using the same strobes. Two level-sensitive interrupt requests come from the fill levels. One asks the host to drain the receive queue. The other asks it to refill the transmit queue.

A single write to the control field does several things. It stores the two trigger-level codes, a stored-only DMA-mode flag and the queue-enable flag. In the same write it can flush either queue. When the queues are disabled, each direction acts as a one-character holding register. Any change of the enable flag empties both queues. Read data comes back one cycle after a pop, from an output register. That register keeps its value when a pop finds the queue empty.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` is 0, both counts are 0, `irq_rx_ready` is 0 and `irq_tx_thre` is 1.
- R2: `cfg_rdata` returns the stored fields in this layout: bits 7:6 are the receive trigger code, bits 5:4 the transmit trigger code, bit 3 the DMA-mode flag and bit 0 the enable flag. Bits 2:1 always read 0. The DMA-mode flag changes no other output.
- R3: With bit 0 set, each queue holds up to 16 characters in first-in first-out order. A popped character appears on the matching dout port in the cycle after the pop strobe.
- R4: With bit 0 clear, each queue holds at most one character, and a push into an occupied holding register is discarded.
- R5: With bit 0 set, `irq_rx_ready` is 1 exactly when the receive count is at least the level picked by bits 7:6 (code 0/1/2/3 gives 1/4/8/14).
- R6: With bit 0 clear, bits 7:6 are ignored and `irq_rx_ready` is 1 exactly when the receive holding register is occupied.
- R7: `irq_tx_thre` is 1 when the transmit count is at or below the level picked by bits 5:4 (code 0/1/2/3 gives 1/4/8/12) with bit 0 set. With bit 0 clear, it is 1 when the transmit count is 0.
- R8: A control write with bit 2 set empties the transmit queue and leaves the receive queue alone. A transmit push in the same cycle is dropped.
- R9: A control write with bit 1 set empties the receive queue and leaves the transmit queue alone. A receive push in the same cycle is dropped.
- R10: A control write that changes bit 0 empties both queues. A write that keeps bit 0 unchanged empties neither.
- R11: A push into a full queue is discarded, the count does not change, and `rx_overrun` (receive) or `tx_overflow` (transmit) is 1 for the one cycle after that push.
- R12: A pop from an empty queue leaves the count at 0 and leaves the dout port at its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Write strobe for the control field |
| cfg_wdata | input | 8 | Control field write value |
| cfg_rdata | output | 8 | Control field read value |
| rx_push | input | 1 | Receive shifter delivers a character |
| rx_data | input | 8 | Character from the receive shifter |
| rx_pop | input | 1 | Host takes a received character |
| rx_dout | output | 8 | Last character popped from the receive queue |
| rx_count | output | 5 | Receive queue occupancy |
| rx_overrun | output | 1 | One-cycle pulse after a discarded receive push |
| irq_rx_ready | output | 1 | Receive data-ready interrupt |
| tx_push | input | 1 | Host writes a character to send |
| tx_data | input | 8 | Character to send |
| tx_pop | input | 1 | Transmit shifter takes a character |
| tx_dout | output | 8 | Last character popped from the transmit queue |
| tx_count | output | 5 | Transmit queue occupancy |
| tx_overflow | output | 1 | One-cycle pulse after a discarded transmit push |
| irq_tx_thre | output | 1 | Transmit threshold-empty interrupt |

## Verification
The bench builds the block with its defaults: 8-bit characters and 16-entry queues. This depth lets a directed sequence fill each queue completely. Every trigger level, including 14 and 12, can then be crossed one push at a time. The 16-entry depth also lets the bench reach the full boundary, where a 17th push must be discarded. The one-entry disabled mode is exercised with the same parameters, by clearing the enable flag.

// File: rtl/ufc_pkg.sv
package ufc_pkg;

  typedef struct packed {
    logic [1:0] rx_trig;
    logic [1:0] tx_trig;
    logic       dma;
    logic       en;
  } ufc_cfg_t;

  function automatic int rx_trig_level(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int tx_trig_level(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 12;
    endcase
  endfunction

endpackage

// File: rtl/ufc_rst_sync.sv
module ufc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ufc_char_fifo.sv
module ufc_char_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5,
  parameter int PTR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deep,
  input  logic              clear,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic [CNT_W-1:0]  count,
  output logic              drop
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_n, rd_q, rd_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n, cap;
  logic [DATA_W-1:0] dout_q, dout_n;
  logic              drop_q, drop_n;
  logic              full, push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    cap     = deep ? CNT_W'(DEPTH) : CNT_W'(1);
    full    = (cnt_q >= cap);
    pop_ok  = pop & ~clear & (cnt_q != '0);
    push_ok = push & ~clear & (~full | pop_ok);
    drop_n  = push & ~clear & ~push_ok;
    wr_n    = wr_q;
    rd_n    = rd_q;
    cnt_n   = cnt_q;
    dout_n  = dout_q;
    if (clear) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end else begin
      if (push_ok) wr_n = bump(wr_q);
      if (pop_ok) begin
        rd_n   = bump(rd_q);
        dout_n = mem[rd_q];
      end
      case ({push_ok, pop_ok})
        2'b10:   cnt_n = cnt_q + 1'b1;
        2'b01:   cnt_n = cnt_q - 1'b1;
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      dout_q <= '0;
      drop_q <= 1'b0;
    end else begin
      wr_q   <= wr_n;
      rd_q   <= rd_n;
      cnt_q  <= cnt_n;
      dout_q <= dout_n;
      drop_q <= drop_n;
    end
  end

  assign dout  = dout_q;
  assign count = cnt_q;
  assign drop  = drop_q;
endmodule

// File: rtl/ufc_ctrl_reg.sv
module ufc_ctrl_reg (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [7:0]      wdata,
  output ufc_pkg::ufc_cfg_t cfg,
  output logic            rx_clear,
  output logic            tx_clear,
  output logic [7:0]      rdata
);
  ufc_pkg::ufc_cfg_t cfg_q, cfg_n;
  logic              en_flip;

  always_comb begin
    cfg_n   = cfg_q;
    en_flip = wr & (wdata[0] != cfg_q.en);
    if (wr) begin
      cfg_n.rx_trig = wdata[7:6];
      cfg_n.tx_trig = wdata[5:4];
      cfg_n.dma     = wdata[3];
      cfg_n.en      = wdata[0];
    end
    rx_clear = en_flip | (wr & wdata[1]);
    tx_clear = en_flip | (wr & wdata[2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_n;
  end

  assign cfg   = cfg_q;
  assign rdata = {cfg_q.rx_trig, cfg_q.tx_trig, cfg_q.dma, 2'b00, cfg_q.en};
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_dout,
  output logic [CNT_W-1:0]  rx_count,
  output logic              rx_overrun,
  output logic              irq_rx_ready,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_dout,
  output logic [CNT_W-1:0]  tx_count,
  output logic              tx_overflow,
  output logic              irq_tx_thre
);
  logic              rst_n_int;
  ufc_pkg::ufc_cfg_t cfg;
  logic              rx_clear, tx_clear;
  int                rx_lvl, tx_lvl;

  ufc_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  ufc_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr       (cfg_wr),
    .wdata    (cfg_wdata),
    .cfg      (cfg),
    .rx_clear (rx_clear),
    .tx_clear (tx_clear),
    .rdata    (cfg_rdata)
  );

  ufc_char_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_rx (
    .clk   (clk),
    .rst_n (rst_n_int),
    .deep  (cfg.en),
    .clear (rx_clear),
    .push  (rx_push),
    .din   (rx_data),
    .pop   (rx_pop),
    .dout  (rx_dout),
    .count (rx_count),
    .drop  (rx_overrun)
  );

  ufc_char_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_tx (
    .clk   (clk),
    .rst_n (rst_n_int),
    .deep  (cfg.en),
    .clear (tx_clear),
    .push  (tx_push),
    .din   (tx_data),
    .pop   (tx_pop),
    .dout  (tx_dout),
    .count (tx_count),
    .drop  (tx_overflow)
  );

  always_comb begin
    rx_lvl       = ufc_pkg::rx_trig_level(cfg.rx_trig);
    tx_lvl       = ufc_pkg::tx_trig_level(cfg.tx_trig);
    irq_rx_ready = cfg.en ? (int'(rx_count) >= rx_lvl) : (rx_count != '0);
    irq_tx_thre  = cfg.en ? (int'(tx_count) <= tx_lvl) : (tx_count == '0);
  end
endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [7:0]        cfg_wdata,
  input logic [7:0]        cfg_rdata,
  input logic              rx_push,
  input logic              rx_pop,
  input logic [DATA_W-1:0] rx_dout,
  input logic [CNT_W-1:0]  rx_count,
  input logic              rx_overrun,
  input logic              irq_rx_ready,
  input logic [CNT_W-1:0]  tx_count
);
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rx_count) <= DEPTH) && (int'(tx_count) <= DEPTH));

  a_r4_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[0] |-> (rx_count <= 1) && (tx_count <= 1));

  a_r6_rx_ready_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[0] |-> (irq_rx_ready == (rx_count != '0)));

  a_r8_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_wdata[2]) |=> (tx_count == '0));

  a_r9_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_wdata[1]) |=> (rx_count == '0));

  a_r10_enable_change: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (cfg_wdata[0] != cfg_rdata[0])) |=> (rx_count == '0) && (tx_count == '0));

  a_r11_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> $past(rx_push) && ($past(rx_count) != '0));

  a_r12_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && (rx_count == '0) && !rx_push && !cfg_wr) |=> (rx_count == '0) && $stable(rx_dout));
endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_wr       (cfg_wr),
  .cfg_wdata    (cfg_wdata),
  .cfg_rdata    (cfg_rdata),
  .rx_push      (rx_push),
  .rx_pop       (rx_pop),
  .rx_dout      (rx_dout),
  .rx_count     (rx_count),
  .rx_overrun   (rx_overrun),
  .irq_rx_ready (irq_rx_ready),
  .tx_count     (tx_count)
);

// File: tb/uart_fifo_ctrl_tb.sv
`timescale 1ns/1ps
module uart_fifo_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic       rx_push, rx_pop, tx_push, tx_pop;
  logic [7:0] rx_data, rx_dout, tx_data, tx_dout;
  logic [4:0] rx_count, tx_count;
  logic       rx_overrun, tx_overflow, irq_rx_ready, irq_tx_thre;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  uart_fifo_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rx_push(rx_push), .rx_data(rx_data), .rx_pop(rx_pop), .rx_dout(rx_dout),
    .rx_count(rx_count), .rx_overrun(rx_overrun), .irq_rx_ready(irq_rx_ready),
    .tx_push(tx_push), .tx_data(tx_data), .tx_pop(tx_pop), .tx_dout(tx_dout),
    .tx_count(tx_count), .tx_overflow(tx_overflow), .irq_tx_thre(irq_tx_thre)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cfg_wr = 0; rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
  endtask

  task automatic cfg(input logic [7:0] v);
    cfg_wr = 1; cfg_wdata = v; step();
  endtask

  task automatic push_rx(input logic [7:0] d);
    rx_push = 1; rx_data = d; step();
  endtask

  task automatic push_tx(input logic [7:0] d);
    tx_push = 1; tx_data = d; step();
  endtask

  task automatic pop_rx();
    rx_pop = 1; step();
  endtask

  task automatic pop_tx();
    tx_pop = 1; step();
  endtask

  function automatic int rx_level(input int code);
    case (code) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
  endfunction

  function automatic int tx_level(input int code);
    case (code) 0: return 1; 1: return 4; 2: return 8; default: return 12; endcase
  endfunction

  task automatic t_reset();
    check("R1 cfg_rdata", cfg_rdata, 0);
    check("R1 rx_count", rx_count, 0);
    check("R1 tx_count", tx_count, 0);
    check("R1 irq_rx_ready", irq_rx_ready, 0);
    check("R1 irq_tx_thre", irq_tx_thre, 1);
  endtask

  task automatic t_cfg_field();
    cfg(8'hFF);
    check("R2 readback flush bits zero", cfg_rdata, 8'hF9);
    push_tx(8'h11);
    cfg(8'hF1);
    check("R2 dma cleared readback", cfg_rdata, 8'hF1);
    check("R2 dma no effect tx_count", tx_count, 1);
    check("R2 dma no effect thre", irq_tx_thre, 1);
    cfg(8'h00);
    check("R10 disable clears tx", tx_count, 0);
  endtask

  task automatic t_disabled();
    cfg(8'hC0);
    push_rx(8'hA1);
    check("R4 rx count one", rx_count, 1);
    check("R6 rx ready ignores code 3", irq_rx_ready, 1);
    push_rx(8'hA2);
    check("R4 second push dropped", rx_count, 1);
    check("R11 overrun pulse disabled", rx_overrun, 1);
    step();
    check("R11 overrun one cycle", rx_overrun, 0);
    pop_rx();
    check("R4 holds first char", rx_dout, 8'hA1);
    check("R6 rx ready cleared", irq_rx_ready, 0);
    check("R7 thre disabled empty", irq_tx_thre, 1);
    push_tx(8'h5A);
    check("R7 thre disabled occupied", irq_tx_thre, 0);
    pop_tx();
    check("R3 tx dout", tx_dout, 8'h5A);
    check("R7 thre after pop", irq_tx_thre, 1);
  endtask

  task automatic t_order();
    cfg(8'h01);
    for (int i = 0; i < 16; i++) push_rx(8'(i * 7 + 3));
    check("R3 rx full count", rx_count, 16);
    push_rx(8'hEE);
    check("R11 rx full drop count", rx_count, 16);
    check("R11 rx overrun pulse", rx_overrun, 1);
    for (int i = 0; i < 16; i++) begin
      pop_rx();
      check("R3 rx order", rx_dout, 8'(i * 7 + 3));
    end
    check("R3 rx drained", rx_count, 0);
    pop_rx();
    check("R12 empty pop count", rx_count, 0);
    check("R12 empty pop dout", rx_dout, 8'(15 * 7 + 3));
    pop_tx();
    check("R12 tx empty pop count", tx_count, 0);
  endtask

  task automatic t_rx_levels();
    for (int code = 0; code < 4; code++) begin
      cfg(8'((code << 6) | 8'h03));
      check("R9 rx flush", rx_count, 0);
      check("R5 not ready empty", irq_rx_ready, 0);
      for (int k = 1; k <= 15; k++) begin
        push_rx(8'(k));
        check("R5 rx ready vs level", irq_rx_ready, (k >= rx_level(code)) ? 1 : 0);
      end
    end
    cfg(8'h03);
  endtask

  task automatic t_tx_levels();
    for (int code = 0; code < 4; code++) begin
      cfg(8'((code << 4) | 8'h05));
      check("R8 tx flush", tx_count, 0);
      check("R7 thre empty", irq_tx_thre, 1);
      for (int k = 1; k <= 16; k++) begin
        push_tx(8'(k));
        check("R7 thre vs level", irq_tx_thre, (k <= tx_level(code)) ? 1 : 0);
      end
      if (code == 3) begin
        push_tx(8'h99);
        check("R11 tx full count", tx_count, 16);
        check("R11 tx overflow pulse", tx_overflow, 1);
        step();
        check("R11 tx overflow one cycle", tx_overflow, 0);
      end
    end
    cfg(8'h05);
  endtask

  task automatic t_flush_isolation();
    cfg(8'h07);
    for (int i = 0; i < 3; i++) push_rx(8'(i));
    for (int i = 0; i < 5; i++) push_tx(8'(i));
    tx_push = 1; tx_data = 8'h42; cfg(8'h05);
    check("R8 tx flushed with push", tx_count, 0);
    check("R8 rx kept", rx_count, 3);
    push_tx(8'h10);
    rx_push = 1; rx_data = 8'h43; cfg(8'h03);
    check("R9 rx flushed with push", rx_count, 0);
    check("R9 tx kept", tx_count, 1);
    pop_tx();
    check("R8 fresh data after flush", tx_dout, 8'h10);
  endtask

  task automatic t_toggle();
    cfg(8'h07);
    push_rx(8'h21); push_rx(8'h22);
    push_tx(8'h31); push_tx(8'h32);
    cfg(8'h41);
    check("R10 same enable keeps rx", rx_count, 2);
    check("R10 same enable keeps tx", tx_count, 2);
    cfg(8'h40);
    check("R10 disable clears rx", rx_count, 0);
    check("R10 disable clears tx", tx_count, 0);
    push_rx(8'h23); push_tx(8'h33);
    cfg(8'h01);
    check("R10 enable clears rx", rx_count, 0);
    check("R10 enable clears tx", tx_count, 0);
  endtask

  initial begin
    rst_n = 0; cfg_wr = 0; cfg_wdata = 0;
    rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0; rx_data = 0; tx_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_cfg_field();
    t_disabled();
    t_order();
    t_rx_levels();
    t_tx_levels();
    t_flush_isolation();
    t_toggle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule